// File: doc/BRIEF.md
# Ternary Response Digitizer with Threshold Sweep

This block decides whether a measured transient response differs from a fault-free reference. Both are sampled integer streams. First, one record of paired samples (reference and measured) is written into a local buffer. After a start pulse, one pass over the buffer finds the smallest and largest reference value. The span between them is divided into equal steps, with one threshold per test.

For each threshold, every sample of both streams is mapped to one of three codes:
- high, when the sample is above the threshold plus a guard margin;
- low, when it is below the threshold minus that margin;
- unresolved, otherwise.

Positions where the two codes disagree are counted as detection instances. When all tests are done, the block gives a one-cycle done pulse. With it come the index of the test that found the most disagreements, that count, and a fault flag. Only integer arithmetic is used. The one division per record is done by a small sequential divider, or by a shift when the divisor is a power of two.

Top module: `ternary_sweep_digitizer`

## Requirements
- R1: A sample codes as high when it is strictly greater than threshold + margin, as low when it is strictly less than threshold − margin, and as unresolved otherwise. A sample exactly on either bound is therefore unresolved.
- R2: The count for a test is the number of sample positions in the record whose reference code and measured code differ.
- R3: The first pass finds the minimum and maximum of the reference samples in the current record only.
- R4: With N tests, test t (t = 0 … N−1) uses the threshold min + (t+1)·floor((max − min)/(N+1)).
- R5: `best_test` is the test with the largest count. When counts are equal, the lower test index wins, so a record with no disagreements reports test 0.
- R6: `fault_found` is 1 exactly when the reported `best_count` is nonzero.
- R7: `done` is high for a single cycle at the end of an analysis. `busy` is high from the cycle after an accepted start until the analysis finishes. The three result outputs change only together with `done` and hold their values until the next `done`.
- R8: The record consists of the samples written since reset or since the last `done`, in write order. Writes are ignored while `busy` is high, in the cycle of an accepted start, and once DEPTH samples are held.
- R9: A start pulse is ignored while `busy` is high or when the buffer holds no samples.
- R10: After reset, `busy`, `done`, `best_test`, `best_count` and `fault_found` are all 0.
- R11: The margin is captured at the accepted start. Changing the `margin` input during an analysis does not change its result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Append one sample pair to the record |
| wr_ref | input | W | Reference sample, unsigned |
| wr_meas | input | W | Measured sample, unsigned |
| start | input | 1 | Begin analysis of the current record |
| margin | input | MW | Guard margin around each threshold, unsigned |
| busy | output | 1 | Analysis in progress |
| done | output | 1 | One-cycle pulse marking valid results |
| best_test | output | clog2(N) | Index of the test with the highest count |
| best_count | output | clog2(DEPTH+1) | Highest detection count over all tests |
| fault_found | output | 1 | Some test found at least one disagreement |

## Verification
Several properties are checked on every cycle:
- the done pulse lasts one cycle, and results move only with it;
- the fault flag agrees with the reported count;
- the scan ends with min ≤ max, and every threshold under test stays inside that range;
- a running count never exceeds the record length, and the best count never falls below a test just tallied;
- the step is the exact floor quotient of the span.

The exact three-level coding at the guard bounds, the threshold placement with a non-exact step, the tie-breaking between tests, and the handling of stray writes, early starts and margin changes during a run can only be shown by the bench's records with precomputed outcomes.

// File: rtl/tsd_pkg.sv
package tsd_pkg;

   typedef enum logic [1:0] {
      TERN_MID  = 2'b00,
      TERN_HIGH = 2'b01,
      TERN_LOW  = 2'b10
   } tern_t;

   typedef enum logic [2:0] {
      PH_IDLE,
      PH_SCAN,
      PH_DIVGO,
      PH_DIVWAIT,
      PH_TEST,
      PH_TALLY,
      PH_FIN
   } phase_t;

   function automatic int bits_for(input int v);
      return (v <= 2) ? 1 : $clog2(v);
   endfunction

endpackage

// File: rtl/tsd_sample_buf.sv
module tsd_sample_buf #(
   parameter int W     = 12,
   parameter int DEPTH = 400,
   parameter int AW    = 9,
   parameter int LANES = 2
) (
   input  logic                 clk,
   input  logic                 wr_en,
   input  logic [AW-1:0]        wr_addr,
   input  logic [LANES*W-1:0]   wr_data,
   input  logic [AW-1:0]        rd_addr,
   output logic [LANES*W-1:0]   rd_data
);

   initial begin
      assert (DEPTH >= 2) else $error("tsd_sample_buf: DEPTH must be at least 2");
      assert ((1 << AW) >= DEPTH) else $error("tsd_sample_buf: AW too narrow for DEPTH");
   end

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      logic [W-1:0] mem [DEPTH];

      always_ff @(posedge clk) begin
         if (wr_en) mem[wr_addr] <= wr_data[g*W +: W];
      end

      assign rd_data[g*W +: W] = mem[rd_addr];
   end

endmodule

// File: rtl/tsd_quantize.sv
module tsd_quantize
   import tsd_pkg::*;
#(
   parameter int W  = 12,
   parameter int MW = 12
) (
   input  logic [W-1:0]  sample,
   input  logic [W-1:0]  thr,
   input  logic [MW-1:0] margin,
   output tern_t         code
);

   localparam int EW = W + 2;

   logic signed [EW-1:0] s_e, t_e, m_e, up_e, lo_e;

   assign s_e  = $signed({2'b00, sample});
   assign t_e  = $signed({2'b00, thr});
   assign m_e  = $signed({{(EW-MW){1'b0}}, margin});
   assign up_e = t_e + m_e;
   assign lo_e = t_e - m_e;

   always_comb begin
      if (s_e > up_e)      code = TERN_HIGH;
      else if (s_e < lo_e) code = TERN_LOW;
      else                 code = TERN_MID;
   end

endmodule

// File: rtl/tsd_step_div.sv
module tsd_step_div #(
   parameter int W   = 12,
   parameter int DIV = 11
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         go,
   input  logic [W-1:0] span,
   output logic         done,
   output logic [W-1:0] quot
);

   localparam bit IS_POW2 = ((DIV & (DIV - 1)) == 0);
   localparam int SH      = (DIV <= 1) ? 0 : $clog2(DIV);
   localparam int RW      = $clog2(DIV + 1);
   localparam int IW      = $clog2(W + 1);

   initial begin
      assert (DIV >= 2) else $error("tsd_step_div: divisor must be at least 2");
      assert (W >= 2) else $error("tsd_step_div: W must be at least 2");
   end

   logic [W-1:0] sp_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  sp_q <= '0;
      else if (go) sp_q <= span;
   end

   if (IS_POW2) begin : g_shift
      logic         dn_q;
      logic [W-1:0] q_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            dn_q <= 1'b0;
            q_q  <= '0;
         end else begin
            dn_q <= go;
            if (go) q_q <= span >> SH;
         end
      end

      assign done = dn_q;
      assign quot = q_q;
   end else begin : g_restore
      logic [W-1:0]  work;
      logic [RW-1:0] rem;
      logic [IW-1:0] iter;
      logic          dn_q;
      logic [RW:0]   trial;
      logic          qbit;
      logic [RW-1:0] nrem;

      assign trial = {rem, work[W-1]};
      assign qbit  = (trial >= (RW+1)'(DIV));
      assign nrem  = qbit ? RW'(trial - (RW+1)'(DIV)) : trial[RW-1:0];

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            work <= '0;
            rem  <= '0;
            iter <= '0;
            dn_q <= 1'b0;
         end else begin
            dn_q <= 1'b0;
            if (go) begin
               work <= span;
               rem  <= '0;
               iter <= IW'(W);
            end else if (iter != '0) begin
               rem  <= nrem;
               work <= {work[W-2:0], qbit};
               iter <= iter - IW'(1);
               if (iter == IW'(1)) dn_q <= 1'b1;
            end
         end
      end

      assign done = dn_q;
      assign quot = work;
   end

   logic [63:0] prod;
   assign prod = 64'(quot) * 64'(DIV);

   AST_STEP_EXACT: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (prod <= 64'(sp_q)) && ((64'(sp_q) - prod) < 64'(DIV))) // R4
      else $error("step is not the floor quotient");

endmodule

// File: rtl/ternary_sweep_digitizer.sv
module ternary_sweep_digitizer
   import tsd_pkg::*;
#(
   parameter int W      = 12,
   parameter int DEPTH  = 400,
   parameter int NTESTS = 10,
   parameter int MW     = 12,
   localparam int AW    = bits_for(DEPTH),
   localparam int LW    = $clog2(DEPTH + 1),
   localparam int TW    = bits_for(NTESTS),
   localparam int CW    = LW
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [W-1:0]  wr_ref,
   input  logic [W-1:0]  wr_meas,
   input  logic          start,
   input  logic [MW-1:0] margin,
   output logic          busy,
   output logic          done,
   output logic [TW-1:0] best_test,
   output logic [CW-1:0] best_count,
   output logic          fault_found
);

   localparam int DIV = NTESTS + 1;

   initial begin
      assert (NTESTS >= 1) else $error("NTESTS must be at least 1");
      assert (W >= 2) else $error("W must be at least 2");
      assert (MW >= 1 && MW <= W) else $error("MW must lie in 1..W");
      assert (DEPTH >= 2) else $error("DEPTH must be at least 2");
   end

   phase_t        phase;
   logic [LW-1:0] wr_ptr, len_q;
   logic [AW-1:0] idx;
   logic [W-1:0]  min_q, max_q, step_q, thr_q;
   logic [MW-1:0] margin_q;
   logic [TW-1:0] test_q, rb_test;
   logic [CW-1:0] cnt_q, rb_cnt;

   logic            start_ok, wr_ok, last_smp, mismatch;
   logic            div_go, div_done;
   logic [W-1:0]    div_quot;
   logic [2*W-1:0]  rd_data;
   logic [W-1:0]    rd_ref;
   tern_t           code [2];

   assign start_ok = start && (phase == PH_IDLE) && (wr_ptr != '0);
   assign wr_ok    = wr_en && (phase == PH_IDLE) && !start_ok && (wr_ptr < LW'(DEPTH));
   assign last_smp = (LW'(idx) == (len_q - LW'(1)));
   assign div_go   = (phase == PH_DIVGO);
   assign busy     = (phase != PH_IDLE);
   assign rd_ref   = rd_data[W-1:0];

   tsd_sample_buf #(.W(W), .DEPTH(DEPTH), .AW(AW), .LANES(2)) u_buf (
      .clk     (clk),
      .wr_en   (wr_ok),
      .wr_addr (wr_ptr[AW-1:0]),
      .wr_data ({wr_meas, wr_ref}),
      .rd_addr (idx),
      .rd_data (rd_data)
   );

   for (genvar q = 0; q < 2; q++) begin : g_quant
      tsd_quantize #(.W(W), .MW(MW)) u_q (
         .sample (rd_data[q*W +: W]),
         .thr    (thr_q),
         .margin (margin_q),
         .code   (code[q])
      );
   end

   assign mismatch = (code[0] != code[1]);

   tsd_step_div #(.W(W), .DIV(DIV)) u_div (
      .clk   (clk),
      .rst_n (rst_n),
      .go    (div_go),
      .span  (max_q - min_q),
      .done  (div_done),
      .quot  (div_quot)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase       <= PH_IDLE;
         wr_ptr      <= '0;
         len_q       <= '0;
         idx         <= '0;
         min_q       <= '0;
         max_q       <= '0;
         step_q      <= '0;
         thr_q       <= '0;
         margin_q    <= '0;
         test_q      <= '0;
         cnt_q       <= '0;
         rb_test     <= '0;
         rb_cnt      <= '0;
         done        <= 1'b0;
         best_test   <= '0;
         best_count  <= '0;
         fault_found <= 1'b0;
      end else begin
         done <= 1'b0;
         if (wr_ok) wr_ptr <= wr_ptr + LW'(1);
         unique case (phase)
            PH_IDLE: begin
               if (start_ok) begin
                  len_q    <= wr_ptr;
                  margin_q <= margin;
                  idx      <= '0;
                  phase    <= PH_SCAN;
               end
            end
            PH_SCAN: begin
               if (idx == '0) begin
                  min_q <= rd_ref;
                  max_q <= rd_ref;
               end else begin
                  if (rd_ref < min_q) min_q <= rd_ref;
                  if (rd_ref > max_q) max_q <= rd_ref;
               end
               if (last_smp) phase <= PH_DIVGO;
               else          idx   <= idx + AW'(1);
            end
            PH_DIVGO: begin
               phase <= PH_DIVWAIT;
            end
            PH_DIVWAIT: begin
               if (div_done) begin
                  step_q  <= div_quot;
                  thr_q   <= min_q + div_quot;
                  test_q  <= '0;
                  idx     <= '0;
                  cnt_q   <= '0;
                  rb_cnt  <= '0;
                  rb_test <= '0;
                  phase   <= PH_TEST;
               end
            end
            PH_TEST: begin
               if (mismatch) cnt_q <= cnt_q + CW'(1);
               if (last_smp) phase <= PH_TALLY;
               else          idx   <= idx + AW'(1);
            end
            PH_TALLY: begin
               if (cnt_q > rb_cnt) begin
                  rb_cnt  <= cnt_q;
                  rb_test <= test_q;
               end
               if (test_q == TW'(NTESTS - 1)) begin
                  phase <= PH_FIN;
               end else begin
                  test_q <= test_q + TW'(1);
                  thr_q  <= thr_q + step_q;
                  cnt_q  <= '0;
                  idx    <= '0;
                  phase  <= PH_TEST;
               end
            end
            PH_FIN: begin
               best_test   <= rb_test;
               best_count  <= rb_cnt;
               fault_found <= (rb_cnt != '0);
               done        <= 1'b1;
               wr_ptr      <= '0;
               phase       <= PH_IDLE;
            end
            default: phase <= PH_IDLE;
         endcase
      end
   end

   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done) // R7
      else $error("done longer than one cycle");

   AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(best_count) || !$stable(best_test) |-> done) // R7
      else $error("result moved without done");

   AST_FAULT_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (fault_found == (best_count != '0))) // R6
      else $error("fault flag disagrees with count");

   AST_BEST_DOMINATES: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_TALLY) |=> (rb_cnt >= $past(cnt_q))) // R5
      else $error("best count below a tallied test");

   AST_RANGE_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_DIVGO) |-> (min_q <= max_q)) // R3
      else $error("scan produced min above max");

   AST_THR_INSIDE: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_TEST) |-> (thr_q >= min_q) && (thr_q <= max_q)) // R4
      else $error("threshold outside reference range");

   AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_TEST || phase == PH_TALLY) |-> (cnt_q <= len_q)) // R2
      else $error("count exceeds record length");

   AST_NO_OVERFILL: assert property (@(posedge clk) disable iff (!rst_n)
      wr_ptr <= LW'(DEPTH)) // R8
      else $error("record longer than buffer");

endmodule

// File: tb/sim_ternary_sweep_digitizer.sv
module sim_ternary_sweep_digitizer;

   localparam int W = 8, DEPTH = 16, NT = 4, MW = 8;
   localparam int TW = 2, CW = 5;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_en = 1'b0;
   logic [W-1:0]  wr_ref = '0, wr_meas = '0;
   logic          start = 1'b0;
   logic [MW-1:0] margin = '0;
   logic          busy, done, fault_found;
   logic [TW-1:0] best_test;
   logic [CW-1:0] best_count;

   int checks = 0;
   int fails  = 0;
   int cyc    = 0;

   always #10 clk = ~clk;

   ternary_sweep_digitizer #(.W(W), .DEPTH(DEPTH), .NTESTS(NT), .MW(MW)) u0 (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_ref(wr_ref), .wr_meas(wr_meas),
      .start(start), .margin(margin), .busy(busy), .done(done),
      .best_test(best_test), .best_count(best_count), .fault_found(fault_found)
   );

   typedef struct packed {
      logic [3:0]  len;
      logic [63:0] refv;
      logic [63:0] measv;
      logic [7:0]  mg;
      logic [1:0]  best;
      logic [4:0]  cnt;
   } vec_t;

   // Sample i sits in byte i. Thresholds use floor((max-min)/5) steps.
   localparam vec_t VECS [11] = '{
      '{4'd6, 64'h0000_3228_1E14_0A00, 64'h0000_3228_1E14_0A00, 8'd2,   2'd0, 5'd0}, // R2 identical
      '{4'd4, 64'h0000_0000_3200_3200, 64'h0000_0000_3200_0032, 8'd0,   2'd0, 5'd2}, // R5 full tie
      '{4'd3, 64'h0000_0000_0064_1900, 64'h0000_0000_0064_2D00, 8'd3,   2'd1, 5'd1}, // R4 test 1 only
      '{4'd3, 64'h0000_0000_0064_2800, 64'h0000_0000_0064_2B00, 8'd3,   2'd0, 5'd0}, // R1 on upper bound
      '{4'd3, 64'h0000_0000_0064_2800, 64'h0000_0000_0064_2C00, 8'd3,   2'd1, 5'd1}, // R1 past upper bound
      '{4'd3, 64'h0000_0000_0064_2500, 64'h0000_0000_0064_2400, 8'd3,   2'd1, 5'd1}, // R1 lower bound
      '{4'd5, 64'h0000_0064_4632_1E00, 64'h0000_0000_1E32_4664, 8'd0,   2'd1, 5'd4}, // R5 tie t1/t2
      '{4'd3, 64'h0000_0000_0008_1103, 64'h0000_0000_0006_1103, 8'd0,   2'd1, 5'd1}, // R4 floor step
      '{4'd3, 64'h0000_0000_0014_1414, 64'h0000_0000_000A_1914, 8'd2,   2'd0, 5'd2}, // R3 flat ref
      '{4'd2, 64'h0000_0000_0000_FF00, 64'h0000_0000_0000_00FF, 8'd255, 2'd0, 5'd0}, // R1 wide margin
      '{4'd2, 64'h0000_0000_0000_FF00, 64'h0000_0000_0000_00FF, 8'd0,   2'd0, 5'd2}  // R3 full range
   };

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic load_rec(input int n, input logic [63:0] r, input logic [63:0] m);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         wr_en   = 1'b1;
         wr_ref  = r[8*i +: 8];
         wr_meas = m[8*i +: 8];
      end
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic pulse_start(input int mg);
      @(negedge clk);
      start  = 1'b1;
      margin = MW'(mg);
      @(negedge clk);
      start  = 1'b0;
   endtask

   task automatic wait_done();
      int n = 0;
      while (done !== 1'b1 && n < 3000) begin
         @(negedge clk);
         n++;
      end
      chk("R7 done seen", int'(done), 1);
   endtask

   task automatic check_idle(input string req, input int cycles);
      int seen = 0;
      for (int i = 0; i < cycles; i++) begin
         @(negedge clk);
         if (busy || done) seen = 1;
      end
      chk(req, seen, 0);
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc == 150000) begin
         fails++;
         $display("FAIL R7 watchdog actual=%0d expected=done", cyc);
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R10 reset state
      chk("R10 busy", int'(busy), 0);
      chk("R10 done", int'(done), 0);
      chk("R10 best_test", int'(best_test), 0);
      chk("R10 best_count", int'(best_count), 0);
      chk("R10 fault_found", int'(fault_found), 0);

      // R9 start on an empty buffer
      pulse_start(0);
      check_idle("R9 empty start ignored", 30);

      // table walk
      for (int v = 0; v < 11; v++) begin
         load_rec(int'(VECS[v].len), VECS[v].refv, VECS[v].measv);
         pulse_start(int'(VECS[v].mg));
         chk("R7 busy after start", int'(busy), 1);
         wait_done();
         chk("R5 best_test", int'(best_test), int'(VECS[v].best));
         chk("R2 best_count", int'(best_count), int'(VECS[v].cnt));
         chk("R6 fault_found", int'(fault_found), int'(VECS[v].cnt != 0));
         @(negedge clk);
         chk("R7 done one cycle", int'(done), 0);
         chk("R7 result held", int'(best_count), int'(VECS[v].cnt));
      end

      // R11 margin change mid-run; R8 write and R9 start while busy
      load_rec(3, 64'h0064_2800, 64'h0064_2B00);
      pulse_start(3);
      @(negedge clk);
      margin  = 8'd0;
      wr_en   = 1'b1;
      wr_ref  = 8'd255;
      wr_meas = 8'd0;
      start   = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
      start = 1'b0;
      wait_done();
      chk("R11 margin captured at start", int'(best_count), 0);
      chk("R9 start while busy harmless", int'(best_test), 0);
      pulse_start(0);
      check_idle("R8 write while busy not kept", 30);

      // R8 buffer full: extra write discarded
      for (int i = 0; i < DEPTH + 1; i++) begin
         @(negedge clk);
         wr_en   = 1'b1;
         wr_ref  = (i < DEPTH) ? W'(i * 10) : 8'd250;
         wr_meas = (i < DEPTH) ? W'(i * 10) : 8'd0;
      end
      @(negedge clk);
      wr_en = 1'b0;
      pulse_start(0);
      wait_done();
      chk("R8 overflow write ignored count", int'(best_count), 0);
      chk("R8 overflow write ignored fault", int'(fault_found), 0);

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule